// File: doc/BRIEF.md
# Protected Byte Update Sequencer

This block sequences a single byte change in a 256-byte erasable/programmable memory, held here as a register array. A host starts a command with a one-cycle request. The command is either a byte update or the programming of a protection fuse. The block then runs a processing period that is counted in host-supplied ticks, and the host watches the busy flag fall to learn that processing has ended. For an update, the stored and supplied bytes are compared to decide whether an erase phase (bits to one), a write phase (bits to zero), both, or neither is needed, and the processing length follows from that choice.

The lowest 32 addresses each own a one-time fuse at the same index. A fuse at 1 leaves its byte open. Programming a fuse drives it to 0 and locks the byte for good, but only if the supplied byte equals the stored one. Every command needs the unlock flag from the security logic, which is sampled when the command is accepted. A command that breaks a rule ends after a short failure period, raises the error flag and changes nothing. A combinational read port exposes any stored byte and its fuse.

Top module: `byteUpdateCtrl`

## Requirements
- R1: After reset busy and error are 0, every byte reads 8'hFF on rdData, and every fuse of addresses 0..31 reads 1 on rdProt; rdProt reads 1 for addresses 32 and above.
- R2: A byte update where the new data needs at least one 0-to-1 bit change and at least one 1-to-0 bit change keeps busy high for exactly 255 ticks; busy never falls in a cycle without a tick.
- R3: A byte update that needs only 0-to-1 changes, only 1-to-0 changes, or no change at all keeps busy high for exactly 124 ticks; the no-change case gives no memory write strobe.
- R4: A successful update with any change pulses memWe exactly once, in the cycle of the final tick, with memWaddr equal to the address and memWdata equal to the supplied data; afterwards rdData returns the supplied data and error is 0.
- R5: An update of an address below 32 whose fuse reads 0 is a failure: 8 ticks of busy, error 1 after busy falls, no strobe, and the stored byte is unchanged.
- R6: A fuse command on an address below 32 with fuse 1 and supplied data equal to the stored byte lasts 124 ticks, pulses protWe once with protWaddr equal to the address, clears the fuse to 0 and leaves error 0.
- R7: A fuse command whose supplied data differs from the stored byte is a failure (8 ticks, error 1, no strobe) and the fuse stays 1.
- R8: A fuse command on a fuse that already reads 0 is a failure (8 ticks, error 1, no strobe) and the fuse stays 0.
- R9: Any command accepted while unlocked is 0 is a failure (8 ticks, error 1, no strobe), with memory and fuses unchanged.
- R10: A fuse command on an address of 32 or above is a failure (8 ticks, error 1, no strobe).
- R11: A request raised while busy is 1, including in the cycle of the final tick, is ignored: busy stays 0 after the running command ends and the memory holds only that command's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command request, taken only while idle |
| cmdIsProt | input | 1 | 0 = byte update, 1 = program fuse |
| cmdAddr | input | 8 | Target address |
| cmdData | input | 8 | New byte, or comparison byte for a fuse command |
| unlocked | input | 1 | Security code verified, sampled at acceptance |
| tick | input | 1 | Processing clock tick |
| rdAddr | input | 8 | Read port address |
| busy | output | 1 | Processing in progress |
| error | output | 1 | Last command failed, valid once busy is 0 |
| memWe | output | 1 | Memory write strobe |
| memWaddr | output | 8 | Memory write address |
| memWdata | output | 8 | Memory write data |
| protWe | output | 1 | Fuse programming strobe |
| protWaddr | output | 5 | Fuse index being programmed |
| rdData | output | 8 | Stored byte at rdAddr |
| rdProt | output | 1 | Fuse at rdAddr (1 when the address has no fuse) |

## Verification
A fresh request can reach the block in the same cycle as the final tick of the running command, when the commit strobe fires and busy falls. The bench raises cmdValid with different data during the run and again together with that last tick. It then requires busy to stay low, a single memory strobe carrying the first command's data, and a readback of that data. A second overlap happens when a fuse is programmed and an update of the same byte follows at once. That update must see the fuse the previous command just cleared and be refused.

// File: rtl/byteUpdateCtrl_pkg.sv
`timescale 1ns/1ps
package byteUpdateCtrl_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic commitMem;
    logic commitProt;
  } dpStrobe_t;

  // facts about the latched command, from datapath to control
  typedef struct packed {
    logic isProt;
    logic inRange;
    logic protBit;
    logic match;
    logic needErase;
    logic needWrite;
  } dpStatus_t;

endpackage

// File: rtl/byteUpdateCtrl_datapath.sv
`timescale 1ns/1ps
module byteUpdateCtrl_datapath
  import byteUpdateCtrl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROT_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic                          cmdIsProt,
  input  logic [ADDR_W-1:0]             cmdAddr,
  input  logic [DATA_W-1:0]             cmdData,
  input  logic [ADDR_W-1:0]             rdAddr,
  output dpStatus_t                     status,
  output logic [ADDR_W-1:0]             latAddr,
  output logic [DATA_W-1:0]             newByte,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdProt
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PROT_W = (PROT_DEPTH > 1) ? $clog2(PROT_DEPTH) : 1;

  logic [DATA_W-1:0]     memArr [DEPTH];
  logic [PROT_DEPTH-1:0] protBits;
  logic [DATA_W-1:0]     latData;
  logic                  latIsProt;
  logic [DATA_W-1:0]     oldByte;
  logic                  inRange;
  logic                  rdInRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr   <= '0;
      latData   <= '0;
      latIsProt <= 1'b0;
    end else if (strobe.capture) begin
      latAddr   <= cmdAddr;
      latData   <= cmdData;
      latIsProt <= cmdIsProt;
    end
  end

  // erased state of the array and of the fuses is all ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else if (strobe.commitMem) begin
      memArr[latAddr] <= newByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protBits <= '1;
    end else if (strobe.commitProt && inRange) begin
      protBits[latAddr[PROT_W-1:0]] <= 1'b0;
    end
  end

  always_comb begin
    oldByte   = memArr[latAddr];
    inRange   = (int'(latAddr) < PROT_DEPTH);
    rdInRange = (int'(rdAddr) < PROT_DEPTH);

    status.isProt    = latIsProt;
    status.inRange   = inRange;
    status.protBit   = inRange ? protBits[latAddr[PROT_W-1:0]] : 1'b1;
    status.match     = (oldByte == latData);
    status.needErase = |(~oldByte & latData);
    status.needWrite = |(oldByte & ~latData);

    // erase result is all ones, then the write phase clears bits
    newByte = (status.needErase ? {DATA_W{1'b1}} : oldByte) & latData;

    rdData = memArr[rdAddr];
    rdProt = rdInRange ? protBits[rdAddr[PROT_W-1:0]] : 1'b1;
  end

endmodule

// File: rtl/byteUpdateCtrl_control.sv
`timescale 1ns/1ps
module byteUpdateCtrl_control
  import byteUpdateCtrl_pkg::*;
#(
  parameter int TICKS_BOTH = 255,
  parameter int TICKS_ONE  = 124,
  parameter int TICKS_FAIL = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      unlocked,
  input  logic      tick,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      error
);

  localparam int CNT_W = $clog2(TICKS_BOTH + 1);
  localparam logic [CNT_W-1:0] LAST_BOTH = CNT_W'(TICKS_BOTH - 1);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(TICKS_ONE - 1);
  localparam logic [CNT_W-1:0] LAST_FAIL = CNT_W'(TICKS_FAIL - 1);

  logic             busyQ;
  logic             errorQ;
  logic             unlockQ;
  logic [CNT_W-1:0] cntQ;
  logic             fail;
  logic [CNT_W-1:0] lastIdx;
  logic             lastTick;

  always_comb begin
    if (!unlockQ)          fail = 1'b1;
    else if (status.isProt) fail = !status.inRange || !status.protBit || !status.match;
    else                    fail = status.inRange && !status.protBit;

    if (fail)                                       lastIdx = LAST_FAIL;
    else if (!status.isProt && status.needErase && status.needWrite) lastIdx = LAST_BOTH;
    else                                            lastIdx = LAST_ONE;

    lastTick = busyQ && tick && (cntQ == lastIdx);

    strobe.capture    = !busyQ && cmdValid;
    strobe.commitMem  = lastTick && !fail && !status.isProt &&
                        (status.needErase || status.needWrite);
    strobe.commitProt = lastTick && !fail && status.isProt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      errorQ  <= 1'b0;
      unlockQ <= 1'b0;
      cntQ    <= '0;
    end else if (strobe.capture) begin
      busyQ   <= 1'b1;
      errorQ  <= 1'b0;
      unlockQ <= unlocked;
      cntQ    <= '0;
    end else if (lastTick) begin
      busyQ  <= 1'b0;
      errorQ <= fail;
      cntQ   <= '0;
    end else if (busyQ && tick) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign busy  = busyQ;
  assign error = errorQ;

endmodule

// File: rtl/byteUpdateCtrl.sv
`timescale 1ns/1ps
module byteUpdateCtrl
  import byteUpdateCtrl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROT_DEPTH = 32,
  parameter int TICKS_BOTH = 255,
  parameter int TICKS_ONE  = 124,
  parameter int TICKS_FAIL = 8,
  localparam int PROT_W    = (PROT_DEPTH > 1) ? $clog2(PROT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsProt,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              unlocked,
  input  logic              tick,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              error,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWaddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              protWe,
  output logic [PROT_W-1:0] protWaddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdProt
);

  dpStrobe_t         strobe;
  dpStatus_t         status;
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] newByte;

  byteUpdateCtrl_control #(
    .TICKS_BOTH(TICKS_BOTH),
    .TICKS_ONE (TICKS_ONE),
    .TICKS_FAIL(TICKS_FAIL)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .unlocked(unlocked),
    .tick    (tick),
    .status  (status),
    .strobe  (strobe),
    .busy    (busy),
    .error   (error)
  );

  byteUpdateCtrl_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PROT_DEPTH(PROT_DEPTH)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdIsProt(cmdIsProt),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .rdAddr   (rdAddr),
    .status   (status),
    .latAddr  (latAddr),
    .newByte  (newByte),
    .rdData   (rdData),
    .rdProt   (rdProt)
  );

  assign memWe     = strobe.commitMem;
  assign memWaddr  = latAddr;
  assign memWdata  = newByte;
  assign protWe    = strobe.commitProt;
  assign protWaddr = latAddr[PROT_W-1:0];

endmodule

// File: rtl/byteUpdateCtrl_chk.sv
`timescale 1ns/1ps
module byteUpdateCtrl_chk #(
  parameter int TICKS_BOTH = 255,
  parameter int TICKS_ONE  = 124,
  parameter int TICKS_FAIL = 8
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic unlocked,
  input logic tick,
  input logic busy,
  input logic error,
  input logic memWe,
  input logic protWe
);

  localparam int CW = $clog2(TICKS_BOTH + 2);

  logic [CW-1:0] tickCnt;
  logic          lockedCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt   <= '0;
      lockedCmd <= 1'b0;
    end else begin
      if (!busy)     tickCnt <= '0;
      else if (tick) tickCnt <= tickCnt + 1'b1;
      if (!busy && cmdValid) lockedCmd <= !unlocked;
    end
  end

  // R2
  r2_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (tickCnt == CW'(TICKS_BOTH) || tickCnt == CW'(TICKS_ONE) ||
                     tickCnt == CW'(TICKS_FAIL)));

  // R2
  r2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> busy);

  // R11
  r11_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid));

  // R4
  r4_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || protWe) |-> (busy && tick));

  // R4
  r4_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, protWe}));

  // R4
  r4_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || protWe) |=> (!busy && !error));

  // R9
  r9_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lockedCmd) |-> !(memWe || protWe));

endmodule

bind byteUpdateCtrl byteUpdateCtrl_chk #(
  .TICKS_BOTH(TICKS_BOTH),
  .TICKS_ONE (TICKS_ONE),
  .TICKS_FAIL(TICKS_FAIL)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .unlocked(unlocked),
  .tick    (tick),
  .busy    (busy),
  .error   (error),
  .memWe   (memWe),
  .protWe  (protWe)
);

// File: tb/test_byteUpdateCtrl.sv
`timescale 1ns/1ps
module test_byteUpdateCtrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdIsProt = 1'b0;
  logic [7:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic       unlocked = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] rdAddr = '0;
  logic       busy, error, memWe, protWe, rdProt;
  logic [7:0] memWaddr, memWdata, rdData;
  logic [4:0] protWaddr;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  logic [7:0] refMem [256];
  logic       refProt [32];

  always #2 clk = ~clk;

  byteUpdateCtrl i_byteUpdateCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsProt(cmdIsProt),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .unlocked(unlocked), .tick(tick),
    .rdAddr(rdAddr), .busy(busy), .error(error), .memWe(memWe),
    .memWaddr(memWaddr), .memWdata(memWdata), .protWe(protWe),
    .protWaddr(protWaddr), .rdData(rdData), .rdProt(rdProt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one command, with ticks every gap cycles; poke raises a stray request during the run
  task automatic runOp(input bit isProt, input logic [7:0] addr, input logic [7:0] data,
                       input bit unl, input int gap, input bit poke, input string tag);
    logic [7:0] old;
    bit inR, pb, fl, needE, needW;
    int expLen, expMem, expProt;
    int ticks, memCnt, protCnt, cyc;
    logic [7:0] wData, wAddr;
    logic [4:0] pAddr;
    bit t;
    old   = refMem[addr];
    inR   = (addr < 8'd32);
    pb    = inR ? refProt[addr[4:0]] : 1'b1;
    needE = |(~old & data);
    needW = |(old & ~data);
    if (!unl)        fl = 1'b1;
    else if (isProt) fl = !inR || !pb || (old != data);
    else             fl = inR && !pb;
    if (fl)                          expLen = 8;
    else if (!isProt && needE && needW) expLen = 255;
    else                             expLen = 124;
    expMem  = (!fl && !isProt && (needE || needW)) ? 1 : 0;
    expProt = (!fl && isProt) ? 1 : 0;

    @(negedge clk);
    cmdIsProt = isProt; cmdAddr = addr; cmdData = data; unlocked = unl;
    cmdValid = 1'b1; tick = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0; cmdData = ~data;
    ticks = 0; memCnt = 0; protCnt = 0; cyc = 0; wData = '0; wAddr = '0; pAddr = '0;
    while (busy && cyc < 3000) begin
      t = ((cyc % gap) == (gap - 1));
      tick = t;
      if (t) ticks++;
      cmdValid = poke && ((ticks == 1 && t) || (ticks == expLen && t));
      #1;
      if (memWe)  begin memCnt++;  wData = memWdata; wAddr = memWaddr; end
      if (protWe) begin protCnt++; pAddr = protWaddr; end
      @(negedge clk);
      cyc++;
    end
    tick = 1'b0; cmdValid = 1'b0;
    chk(!busy, {tag, " busy ended"}, busy, 0);
    chk(ticks == expLen, {tag, " tick length"}, ticks, expLen);
    chk(error == fl, {tag, " error flag"}, error, fl);
    chk(memCnt == expMem, {tag, " memWe count"}, memCnt, expMem);
    chk(protCnt == expProt, {tag, " protWe count"}, protCnt, expProt);
    if (expMem == 1) begin
      chk(wData == data, {tag, " memWdata"}, wData, data);
      chk(wAddr == addr, {tag, " memWaddr"}, wAddr, addr);
    end
    if (expProt == 1) chk(pAddr == addr[4:0], {tag, " protWaddr"}, pAddr, addr[4:0]);
    if (expMem == 1)  refMem[addr] = data;
    if (expProt == 1) refProt[addr[4:0]] = 1'b0;
    rdAddr = addr; #1;
    chk(rdData == refMem[addr], {tag, " readback"}, rdData, refMem[addr]);
    chk(rdProt == (inR ? refProt[addr[4:0]] : 1'b1), {tag, " fuse readback"}, rdProt,
        inR ? refProt[addr[4:0]] : 1'b1);
    if (poke) begin
      @(negedge clk);
      chk(!busy, {tag, " R11 stray request ignored"}, busy, 0);
    end
  endtask

  initial begin
    int bad;
    for (int i = 0; i < 256; i++) refMem[i] = 8'hFF;
    for (int i = 0; i < 32; i++) refProt[i] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!error, "R1 error after reset", error, 0);
    bad = 0;
    for (int a = 0; a < 256; a++) begin
      rdAddr = 8'(a); #0.1;
      if (rdData != 8'hFF || rdProt != 1'b1) bad++;
    end
    chk(bad == 0, "R1 erased array and fuses", bad, 0);

    // R2 R3 R4 data pattern sweep over open addresses
    runOp(0, 8'd100, 8'hFF, 1, 1, 0, "R3 no change");
    runOp(0, 8'd100, 8'h0F, 1, 1, 0, "R3 write only");
    runOp(0, 8'd100, 8'h3C, 1, 1, 0, "R2 erase and write");
    runOp(0, 8'd100, 8'hFF, 1, 2, 0, "R3 erase only");
    runOp(0, 8'd100, 8'hA5, 1, 3, 0, "R4 write only slow ticks");
    runOp(0, 8'd100, 8'h5A, 1, 1, 0, "R2 both phases");
    for (int i = 0; i < 12; i++)
      runOp(0, 8'(200 + (i % 4)), 8'((i * 37 + 11) & 255), 1, 1, 0, "R4 sweep");
    runOp(0, 8'd255, 8'h00, 1, 1, 0, "R4 top address");

    // R6 R7 R8 R5 fuse handling on one byte
    runOp(0, 8'd3, 8'h5A, 1, 1, 0, "R4 prepare byte 3");
    runOp(1, 8'd3, 8'h5B, 1, 1, 0, "R7 mismatch fuse write");
    runOp(1, 8'd3, 8'h5A, 1, 1, 0, "R6 matching fuse write");
    runOp(0, 8'd3, 8'h00, 1, 1, 0, "R5 update of protected byte");
    runOp(1, 8'd3, 8'h5A, 1, 1, 0, "R8 rewrite cleared fuse");
    runOp(1, 8'd32, 8'hFF, 1, 1, 0, "R10 fuse beyond range");

    // near-exhaustive over the protected window: fuse even addresses, update all
    for (int a = 0; a < 32; a += 2)
      if (a != 2) runOp(1, 8'(a), refMem[a], 1, 1, 0, "R6 fuse sweep");
    for (int a = 0; a < 32; a++)
      runOp(0, 8'(a), 8'((a * 13 + 7) & 255), 1, 1, 0, "R5 update sweep");

    // R9 locked commands
    runOp(0, 8'd50, 8'h12, 0, 1, 0, "R9 locked update");
    runOp(1, 8'd5, refMem[5], 0, 1, 0, "R9 locked fuse write");

    // R11 stray requests during a run
    runOp(0, 8'd60, 8'hC3, 1, 1, 1, "R11 poke during both phases");
    runOp(0, 8'd61, 8'h81, 1, 2, 1, "R11 poke during single phase");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule